// File: doc/BRIEF.md
# Configuration Memory Checksum Engine

This block computes a 16-bit checksum over a contiguous range of a byte-addressed configuration memory. A caller pulses a start input together with a start address and a byte count. The engine then reads the range through a synchronous read port at one byte per cycle, pairs the bytes into big-endian 16-bit words, and folds each word into a running checksum. When the last word has been folded, it raises a one-cycle done pulse. The result stays on its output until the next accepted start, so the caller can store it wherever the data layout calls for.

The fold is a fixed nibble-based shift-and-XOR network, not a generic polynomial divider. An odd trailing byte is treated as the upper half of a final word whose lower half is zero. A typical use covers a 248-byte parameter block and writes the result back as a word at a later offset. That write-back, and the memory itself, are outside this block.

Top module: `cfgsum_engine`

## Requirements
- R1: After reset, done_o, busy_o and rd_en_o are 0 and sum_o is 0x0000.
- R2: The checksum is seeded with 0xFFFF on every accepted start. A byte count of zero issues no read and raises done_o in the cycle right after the start edge, with sum_o = 0xFFFF.
- R3: For a count N > 0, rd_en_o is high for exactly N consecutive cycles, beginning the cycle after the start edge. rd_addr_o starts at start_addr_i and increases by one each cycle.
- R4: Words are big-endian: the byte at the lower address forms bits 15:8 and the next byte forms bits 7:0.
- R5: Each word w updates the checksum s as follows. Let x = s XOR w, a = x[3:0] and b = x[7:4] XOR a. The new s is (s >> 8) XOR (a << 3) XOR (a << 8) XOR b XOR (b << 7) XOR (b << 12), truncated to 16 bits.
- R6: When N is odd, the last byte is folded as the word {byte, 8'h00}.
- R7: For N > 0, done_o is a single-cycle pulse seen N+1 edges after the start edge. busy_o is high from the start edge until that same edge, and done_o is never high while busy_o is high.
- R8: sum_o holds its value from the done pulse until the next accepted start.
- R9: A start asserted while busy_o is high is ignored. The read sequence and the result of the running job are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| start_addr_i | input | ADDR_W | First byte address |
| byte_cnt_i | input | CNT_W | Number of bytes to cover |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | ADDR_W | Memory read address |
| rd_data_i | input | 8 | Read data, valid one cycle after rd_en_o |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 16 | Checksum result |

## Verification
Edge 0 is the clock edge that samples the start. The read strobe and address for byte k are due in the cycle after edge k. The done pulse and the final checksum are due after edge N+1, or after edge 0 for a zero count. The bench drives inputs and samples outputs on the falling edge. For each job it walks these edges one by one and compares strobe, address, busy, done and checksum against values computed from the requirements. After each job it idles for a few cycles to confirm that the result holds. One scenario raises a second start at edge 3 of a running job and confirms that the original schedule and result are unaffected.

// File: rtl/cfgsum_pkg.sv
package cfgsum_pkg;

   localparam int SUM_W = 16;
   typedef logic [SUM_W-1:0] sum_t;
   localparam sum_t SUM_SEED = 16'hFFFF;

   // One fold step of the nibble shift-and-XOR network.
   function automatic sum_t fold_word(sum_t prev, sum_t word);
      sum_t       mix;
      sum_t       acc;
      logic [3:0] lo;
      logic [3:0] hi;
      mix = prev ^ word;
      lo  = mix[3:0];
      hi  = mix[7:4] ^ lo;
      acc = prev >> 8;
      acc = acc ^ (({12'h000, lo} << 3) | ({12'h000, lo} << 8));
      acc = acc ^ ({12'h000, hi} | ({12'h000, hi} << 7) | ({12'h000, hi} << 12));
      return acc;
   endfunction

endpackage

// File: rtl/cfgsum_fetch.sv
module cfgsum_fetch #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              beat_vld_o,
   output logic              beat_last_o,
   output logic              busy_o
);

   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic              busy_q;
   logic              vld_q;
   logic              last_q;

   assign rd_en_o     = busy_q && (left_q != '0);
   assign rd_addr_o   = addr_q;
   assign beat_vld_o  = vld_q;
   assign beat_last_o = last_q;
   assign busy_o      = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
         busy_q <= 1'b0;
         vld_q  <= 1'b0;
         last_q <= 1'b0;
      end else begin
         vld_q  <= rd_en_o;
         last_q <= rd_en_o && (left_q == CNT_ONE);
         if (launch_i) begin
            addr_q <= base_i;
            left_q <= count_i;
            busy_q <= 1'b1;
         end else begin
            if (rd_en_o) begin
               addr_q <= addr_q + ADDR_ONE;
               left_q <= left_q - CNT_ONE;
            end
            if (vld_q && last_q) busy_q <= 1'b0;
         end
      end
   end

   // R3 / R9: a running read stream steps by one and is never reloaded
   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_o && left_q != CNT_ONE) |=> (rd_en_o && rd_addr_o == $past(rd_addr_o) + ADDR_ONE));

   // R3: no read follows the final byte
   a_r3_no_read_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      last_q |-> !rd_en_o);

   // R7: returned last byte ends the job
   a_r7_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && last_q) |=> !busy_o);

endmodule

// File: rtl/cfgsum_pack.sv
module cfgsum_pack (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear_i,
   input  logic        beat_vld_i,
   input  logic        beat_last_i,
   input  logic [7:0]  byte_i,
   output logic        word_vld_o,
   output logic [15:0] word_o
);

   logic       phase_q;
   logic [7:0] hi_q;

   assign word_vld_o = beat_vld_i && (phase_q || beat_last_i);
   assign word_o     = phase_q ? {hi_q, byte_i} : {byte_i, 8'h00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         hi_q    <= '0;
      end else if (clear_i) begin
         phase_q <= 1'b0;
      end else if (beat_vld_i) begin
         if (phase_q) begin
            phase_q <= 1'b0;
         end else if (!beat_last_i) begin
            hi_q    <= byte_i;
            phase_q <= 1'b1;
         end
      end
   end

   // R6: a job never leaves a half word pending
   a_r6_no_stray_half: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld_i && beat_last_i) |=> !phase_q);

   // R4: the held upper byte is the one taken on the previous beat
   a_r4_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld_i && !beat_last_i && !phase_q && !clear_i) |=> (hi_q == $past(byte_i)));

endmodule

// File: rtl/cfgsum_fold.sv
module cfgsum_fold
   import cfgsum_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic seed_i,
   input  logic word_vld_i,
   input  sum_t word_i,
   output sum_t sum_o
);

   sum_t sum_q;

   assign sum_o = sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sum_q <= '0;
      else if (seed_i)     sum_q <= SUM_SEED;
      else if (word_vld_i) sum_q <= fold_word(sum_q, word_i);
   end

   // R2: every accepted job begins from the seed
   a_r2_seed: assert property (@(posedge clk) disable iff (!rst_n)
      seed_i |=> (sum_o == 16'hFFFF));

   // R8: no word, no change
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_i && !word_vld_i) |=> $stable(sum_o));

endmodule

// File: rtl/cfgsum_engine.sv
module cfgsum_engine
   import cfgsum_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [CNT_W-1:0]  byte_cnt_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [15:0]       sum_o
);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("cfgsum_engine: ADDR_W must be 1..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("cfgsum_engine: CNT_W must be 1..32");
      end
   endgenerate

   logic        accept;
   logic        launch;
   logic        empty_job;
   logic        beat_vld;
   logic        beat_last;
   logic        word_vld;
   logic [15:0] word;
   logic        done_q;

   assign accept    = start_i && !busy_o;
   assign empty_job = accept && (byte_cnt_i == '0);
   assign launch    = accept && (byte_cnt_i != '0);

   cfgsum_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch_i    (launch),
      .base_i      (start_addr_i),
      .count_i     (byte_cnt_i),
      .rd_en_o     (rd_en_o),
      .rd_addr_o   (rd_addr_o),
      .beat_vld_o  (beat_vld),
      .beat_last_o (beat_last),
      .busy_o      (busy_o)
   );

   cfgsum_pack u_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (accept),
      .beat_vld_i  (beat_vld),
      .beat_last_i (beat_last),
      .byte_i      (rd_data_i),
      .word_vld_o  (word_vld),
      .word_o      (word)
   );

   cfgsum_fold u_fold (
      .clk        (clk),
      .rst_n      (rst_n),
      .seed_i     (accept),
      .word_vld_i (word_vld),
      .word_i     (word),
      .sum_o      (sum_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= empty_job || (beat_vld && beat_last);
   end

   assign done_o = done_q;

   // R7: completion is never reported during a job
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R2: an empty job reads nothing and finishes at once with the seed
   a_r2_empty_job: assert property (@(posedge clk) disable iff (!rst_n)
      empty_job |=> (done_o && !rd_en_o && !busy_o && sum_o == 16'hFFFF));

   // R9: a start while busy leaves the job running
   a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o && rd_en_o) |=> busy_o);

endmodule

// File: tb/cfgsum_engine_bench.sv
module cfgsum_engine_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] start_addr_i = '0;
   logic [CW-1:0] byte_cnt_i = '0;
   logic          rd_en_o;
   logic [AW-1:0] rd_addr_o;
   logic [7:0]    rd_data_i;
   logic          busy_o;
   logic          done_o;
   logic [15:0]   sum_o;

   logic [7:0] mem [256];
   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk) begin
      if (rd_en_o) rd_data_i <= mem[rd_addr_o[7:0]];
   end

   cfgsum_engine #(.ADDR_W(AW), .CNT_W(CW)) u_cfgsum_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .start_addr_i (start_addr_i),
      .byte_cnt_i   (byte_cnt_i),
      .rd_en_o      (rd_en_o),
      .rd_addr_o    (rd_addr_o),
      .rd_data_i    (rd_data_i),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .sum_o        (sum_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Reference step written directly from R5
   function automatic logic [15:0] ref_step(logic [15:0] s, logic [15:0] w);
      logic [15:0] x;
      logic [15:0] a;
      logic [15:0] b;
      x = s ^ w;
      a = {12'h000, x[3:0]};
      b = {12'h000, x[7:4] ^ x[3:0]};
      return (s >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
   endfunction

   function automatic logic [15:0] ref_sum(int base, int cnt);
      logic [15:0] s;
      logic [15:0] w;
      s = 16'hFFFF;
      for (int i = 0; i < cnt; i += 2) begin
         w[15:8] = mem[(base + i) & 255];
         w[7:0]  = (i + 1 < cnt) ? mem[(base + i + 1) & 255] : 8'h00;
         s = ref_step(s, w);
      end
      return s;
   endfunction

   // Walk one job edge by edge; optionally raise a second start at edge 3
   task automatic run_job(input int base, input int cnt, input bit intrude, input string req);
      logic [15:0] exp;
      int dedge;
      exp   = ref_sum(base, cnt);
      dedge = (cnt == 0) ? 0 : cnt + 1;
      @(negedge clk);
      start_i      = 1'b1;
      start_addr_i = AW'(base);
      byte_cnt_i   = CW'(cnt);
      @(negedge clk);
      for (int e = 0; e <= dedge + 1; e++) begin
         start_i = 1'b0;
         chk(rd_en_o == (e < cnt), "R3", $sformatf("%s rd_en at edge %0d", req, e), rd_en_o, (e < cnt));
         if (e < cnt)
            chk(rd_addr_o == AW'(base + e), "R3", $sformatf("%s rd_addr at edge %0d", req, e),
                rd_addr_o, base + e);
         chk(done_o == (e == dedge), "R7", $sformatf("%s done at edge %0d", req, e), done_o, (e == dedge));
         chk(busy_o == (e < dedge), "R7", $sformatf("%s busy at edge %0d", req, e), busy_o, (e < dedge));
         if (e == dedge)
            chk(sum_o == exp, req, "checksum at done", sum_o, exp);
         if (intrude && e == 2 && dedge > 4) begin
            start_i      = 1'b1;
            start_addr_i = AW'(base + 100);
            byte_cnt_i   = CW'(1);
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      for (int h = 0; h < 4; h++) begin
         chk(sum_o == exp && !done_o, "R8", $sformatf("%s held result", req), sum_o, exp);
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!done_o && !busy_o && !rd_en_o, "R1", "control outputs in reset", {done_o, busy_o, rd_en_o}, 0);
      chk(sum_o == 16'h0000, "R1", "sum in reset", sum_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_o && !busy_o && !rd_en_o && sum_o == 16'h0, "R1", "idle after reset", sum_o, 0);

      run_job(8'h20, 2, 1'b0, "R4");      // single big-endian pair
      run_job(8'h10, 0, 1'b0, "R2");      // empty job after a nonzero result
      run_job(8'h31, 1, 1'b0, "R6");      // lone odd byte
      run_job(8'h45, 7, 1'b0, "R6");      // odd tail after full words
      run_job(8'h00, 248, 1'b0, "R5");    // full parameter block range
      run_job(8'h40, 12, 1'b1, "R9");     // second start while busy
      run_job(8'h80, 5, 1'b0, "R7");      // back-to-back jobs
      run_job(8'h90, 6, 1'b0, "R7");
      run_job(8'hF0, 0, 1'b0, "R2");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule